// File: doc/BRIEF.md
# Tamper Response Controller

This block watches a single tamper switch input next to a secure real-time clock and reacts when the switch leaves its idle state. The switch can be wired normally-open or normally-closed. A normally-closed switch can be checked on every clock or only on a once-per-second strobe, which saves current. The strobe is derived from the clock and runs only while the oscillator is reported as running. A detected event sets a sticky flag. Depending on the control byte, the event then starts a sequencer that zero-fills the 128-byte user RAM one byte per clock. It also hides the RAM contents from reads and raises a timed clear pulse for an external SRAM, which also requests a system reset.

A single 8-bit control byte is written over a parallel port and can be read back. Bit 0 enables tamper detection. Bit 1 selects normally-closed mode (1) or normally-open mode (0). Bit 2 selects 1 Hz sampling (1) or continuous checking (0). Bit 3 holds the pull-strength select. Bit 4 requests the internal RAM clear. Bit 5 requests the external clear. Bits 7:6 select the clear-pulse width. Other reset sources (supply fail, watchdog expiry, manual reset) are merged with the tamper request into one reset request output.

Top module: `tamper_guard`

## Requirements
- R1: After reset the control byte reads 0x00, and `tamper_flag`, `ext_clr`, `clr_busy` and `rst_req` are all low.
- R2: In normally-open mode (bit 1 = 0) the idle input level is 0 and a 1 on `tamper_in` is an event. The input is checked continuously whatever bit 2 and `osc_on` are.
- R3: In normally-closed mode with bit 2 = 0 the idle level is 1 and a 0 is an event. It is checked continuously, also with `osc_on` low, and the flag rises at most 4 cycles after the input changes.
- R4: In normally-closed mode with bit 2 = 1 the input is judged only on the 1 Hz strobe. The strobe occurs once every TICK_DIV cycles in which `osc_on` is high, and never while `osc_on` is low.
- R5: Events are recognised only while bit 0 is 1. `tamper_flag` stays set after the input returns to idle and clears only when bit 0 is written to 0.
- R6: An event with bit 4 set holds `clr_busy` high for exactly 128 cycles while every RAM byte is written to 0. External RAM writes made while `clr_busy` is high are discarded.
- R7: After an event with bit 4 set, RAM reads return 0xFF until bit 0 is written to 0, after which the stored (cleared) data reads back.
- R8: An event with bit 5 set raises `ext_clr` for 2^W strobe periods, where W is bits 7:6 (1, 2, 4 or 8 periods).
- R9: `rst_req` is high whenever any of `ext_clr`, `pwr_fail`, `wdog_expire` or `man_rst` is high, and low otherwise.
- R10: An event with bits 4 and 5 clear only sets the flag: RAM contents stay readable and unchanged, and `ext_clr` and `clr_busy` stay low.
- R11: Bit 3 is stored and read back but has no effect on detection in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_on | input | 1 | Oscillator running; gates the 1 Hz strobe |
| tamper_in | input | 1 | Tamper switch level (asynchronous) |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte readback |
| ram_we | input | 1 | User RAM write enable |
| ram_addr | input | ADDR_W | User RAM address (write and read) |
| ram_wdata | input | DATA_W | User RAM write data |
| ram_rdata | output | DATA_W | User RAM read data, one cycle after the address |
| pwr_fail | input | 1 | Supply-fail reset source |
| wdog_expire | input | 1 | Watchdog reset source |
| man_rst | input | 1 | Manual reset source |
| tamper_flag | output | 1 | Sticky tamper event flag |
| clr_busy | output | 1 | Internal RAM clear in progress |
| ext_clr | output | 1 | External memory clear pulse |
| rst_req | output | 1 | Combined reset request |

## Verification
The bench builds the block with TICK_DIV = 8, so the once-per-second strobe comes every eight clocks. With that value the slowest sampled detection, all four clear-pulse widths (up to 64 cycles) and the oscillator-off hold-off can each be checked in a few hundred cycles. RAM_DEPTH keeps its default of 128, so the clear sequencer sweeps the full address range. The check covers the 128-cycle busy window and a blocked write placed behind the sweep pointer.

// File: rtl/tg_pkg.sv
package tg_pkg;

    // Control byte layout, MSB first
    typedef struct packed {
        logic [1:0] pulse_sel;   // [7:6] clear pulse width select
        logic       ext_clr;     // [5]   external clear on event
        logic       ram_clr;     // [4]   internal RAM clear on event
        logic       pull_hi;     // [3]   pull strength (stored only)
        logic       sample;      // [2]   1 Hz sampling in closed mode
        logic       nc_mode;     // [1]   normally-closed switch
        logic       enable;      // [0]   detection enable
    } ctrl_t;

    localparam logic [7:0] INVALID_BYTE = 8'hFF;
    localparam int         PCNT_W       = 4;

endpackage

// File: rtl/tg_tick.sv
module tg_tick #(
    parameter int TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_on,
    output logic tick_o
);
    localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (osc_on) begin
            if (cnt_q == W'(TICK_DIV - 1)) begin
                cnt_d  = '0;
                tick_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tg_detect.sv
module tg_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic nc_mode_i,
    input  logic sample_i,
    input  logic tick_i,
    output logic hit_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;
    logic  gated;

    always_comb begin
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        // sampling only applies to the closed-switch mode
        gated   = nc_mode_i & sample_i;
        hit_o   = (st_q.s2 != nc_mode_i) && (!gated || tick_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tg_pulse.sv
module tg_pulse
    import tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_i,
    input  logic [1:0] width_i,
    input  logic       tick_i,
    output logic       active_o
);
    typedef struct packed {
        logic              active;
        logic [PCNT_W-1:0] cnt;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = PCNT_W'(1) << width_i;
        end else if (st_q.active && tick_i) begin
            if (st_q.cnt == PCNT_W'(1)) st_d.active = 1'b0;
            st_d.cnt = st_q.cnt - 1'b1;
        end
        active_o = st_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tg_ram_guard.sv
module tg_ram_guard
    import tg_pkg::*;
#(
    parameter int RAM_DEPTH = 128,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              deselect_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t              st_d, st_q;
    logic [DATA_W-1:0] mem [RAM_DEPTH];

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.ptr = st_q.ptr + 1'b1;
            if (st_q.ptr == ADDR_W'(RAM_DEPTH - 1)) st_d.busy = 1'b0;
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.ptr  = '0;
        end
        st_d.rdata = deselect_i ? DATA_W'(INVALID_BYTE) : mem[addr_i];
        busy_o     = st_q.busy;
        rdata_o    = st_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // storage: the sweep owns the write port while it runs
    always_ff @(posedge clk) begin
        if (st_q.busy)  mem[st_q.ptr] <= '0;
        else if (we_i)  mem[addr_i]   <= wdata_i;
    end

endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tg_pkg::*;
#(
    parameter int RAM_DEPTH = 128,
    parameter int DATA_W    = 8,
    parameter int TICK_DIV  = 32768,
    localparam int ADDR_W   = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_on,
    input  logic              tamper_in,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              ram_we,
    input  logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] ram_rdata,
    input  logic              pwr_fail,
    input  logic              wdog_expire,
    input  logic              man_rst,
    output logic              tamper_flag,
    output logic              clr_busy,
    output logic              ext_clr,
    output logic              rst_req
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  flag;
        logic  desel;
    } top_t;

    top_t st_d, st_q;
    logic tick, hit, event_now, pulse_on;

    tg_tick #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_on (osc_on),
        .tick_o (tick)
    );

    tg_detect i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (tamper_in),
        .nc_mode_i (st_q.ctrl.nc_mode),
        .sample_i  (st_q.ctrl.sample),
        .tick_i    (tick),
        .hit_o     (hit)
    );

    always_comb begin
        st_d      = st_q;
        event_now = st_q.ctrl.enable && !st_q.flag && hit;
        if (st_q.ctrl.enable) begin
            st_d.flag  = st_q.flag  | event_now;
            st_d.desel = st_q.desel | (event_now & st_q.ctrl.ram_clr);
        end else begin
            st_d.flag  = 1'b0;
            st_d.desel = 1'b0;
        end
        if (cfg_we) st_d.ctrl = ctrl_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tg_pulse i_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (event_now & st_q.ctrl.ext_clr),
        .width_i  (st_q.ctrl.pulse_sel),
        .tick_i   (tick),
        .active_o (pulse_on)
    );

    tg_ram_guard #(.RAM_DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) i_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (event_now & st_q.ctrl.ram_clr),
        .deselect_i (st_q.desel),
        .we_i       (ram_we),
        .addr_i     (ram_addr),
        .wdata_i    (ram_wdata),
        .busy_o     (clr_busy),
        .rdata_o    (ram_rdata)
    );

    assign cfg_rdata   = st_q.ctrl;
    assign tamper_flag = st_q.flag;
    assign ext_clr     = pulse_on;
    assign rst_req     = pulse_on | pwr_fail | wdog_expire | man_rst;

endmodule

// File: rtl/tg_checker.sv
module tg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       tamper_flag,
    input logic       clr_busy,
    input logic       ext_clr,
    input logic       rst_req
);
    AST_FLAG_DROPS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |=> !tamper_flag); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_flag && cfg_rdata[0]) |=> tamper_flag); // R5

    AST_CLEAR_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_busy) |-> tamper_flag); // R6

    AST_PULSE_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_clr) |-> tamper_flag); // R8

    AST_PULSE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr |-> rst_req); // R9

endmodule

bind tamper_guard tg_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rdata   (cfg_rdata),
    .tamper_flag (tamper_flag),
    .clr_busy    (clr_busy),
    .ext_clr     (ext_clr),
    .rst_req     (rst_req)
);

// File: tb/test_tamper_guard.sv
module test_tamper_guard;

    localparam int DIV    = 8;
    localparam int ADDR_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              osc_on = 1'b0;
    logic              tamper_in = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic              ram_we = 1'b0;
    logic [ADDR_W-1:0] ram_addr = '0;
    logic [7:0]        ram_wdata = '0;
    logic [7:0]        ram_rdata;
    logic              pwr_fail = 1'b0;
    logic              wdog_expire = 1'b0;
    logic              man_rst = 1'b0;
    logic              tamper_flag, clr_busy, ext_clr, rst_req;

    int nchk  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    tamper_guard #(.RAM_DEPTH(128), .DATA_W(8), .TICK_DIV(DIV)) i_tamper_guard (
        .clk(clk), .rst_n(rst_n), .osc_on(osc_on), .tamper_in(tamper_in),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .pwr_fail(pwr_fail), .wdog_expire(wdog_expire),
        .man_rst(man_rst), .tamper_flag(tamper_flag), .clr_busy(clr_busy),
        .ext_clr(ext_clr), .rst_req(rst_req)
    );

    // {cfg[7:0], tamper_in, osc_on, expected flag}
    localparam logic [10:0] VEC [11] = '{
        {8'h01, 1'b1, 1'b1, 1'b1},  // R2 open mode, active level
        {8'h01, 1'b0, 1'b1, 1'b0},  // R2 open mode, idle level
        {8'h05, 1'b1, 1'b0, 1'b1},  // R2 sample bit and oscillator ignored
        {8'h03, 1'b0, 1'b1, 1'b1},  // R3 closed continuous, active
        {8'h03, 1'b1, 1'b1, 1'b0},  // R3 closed continuous, idle
        {8'h07, 1'b0, 1'b0, 1'b0},  // R4 sampled, oscillator off
        {8'h07, 1'b0, 1'b1, 1'b1},  // R4 sampled, oscillator on
        {8'h03, 1'b0, 1'b0, 1'b1},  // R3 continuous needs no oscillator
        {8'h02, 1'b0, 1'b1, 1'b0},  // R5 disabled
        {8'h0B, 1'b0, 1'b1, 1'b1},  // R11 pull bit in closed mode
        {8'h09, 1'b1, 1'b1, 1'b1}   // R11 pull bit in open mode
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic ram_write(input int a, input logic [7:0] d);
        ram_we = 1'b1; ram_addr = ADDR_W'(a); ram_wdata = d;
        cyc(1);
        ram_we = 1'b0;
    endtask

    task automatic ram_read(input int a, output logic [7:0] d);
        ram_addr = ADDR_W'(a);
        cyc(1);
        d = ram_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int         n;

        cyc(3);
        // R1 reset state
        chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
        chk(!tamper_flag && !ext_clr && !clr_busy && !rst_req, "R1 outputs",
            {tamper_flag, ext_clr, clr_busy, rst_req}, 0);
        rst_n = 1'b1;
        cyc(2);

        // table walk: R2 R3 R4 R5 R11
        for (int i = 0; i < 11; i++) begin
            cfg_write(8'h00);
            tamper_in = VEC[i][2];
            osc_on    = VEC[i][1];
            cyc(4);
            cfg_write(VEC[i][10:3]);
            cyc(3 * DIV + 6);
            chk(tamper_flag == VEC[i][0], $sformatf("vector %0d flag (R2/R3/R4/R5)", i),
                tamper_flag, VEC[i][0]);
            chk(cfg_rdata == VEC[i][10:3], "R11 readback", cfg_rdata, VEC[i][10:3]);
        end

        // R3 latency in continuous closed mode
        cfg_write(8'h00); tamper_in = 1'b1; osc_on = 1'b0; cyc(4);
        cfg_write(8'h03);
        tamper_in = 1'b0;
        n = 0;
        while (!tamper_flag && n < 50) begin cyc(1); n++; end
        chk(n >= 1 && n <= 4, "R3 latency", n, 4);

        // R4 sampled: held off while oscillator is off, then within one strobe period
        cfg_write(8'h00); tamper_in = 1'b1; cyc(4);
        cfg_write(8'h07);
        tamper_in = 1'b0;
        cyc(5 * DIV);
        chk(!tamper_flag, "R4 no strobe without oscillator", tamper_flag, 0);
        osc_on = 1'b1;
        n = 0;
        while (!tamper_flag && n < 100) begin cyc(1); n++; end
        chk(n >= 1 && n <= DIV + 4, "R4 strobe latency", n, DIV + 4);

        // R5 sticky, cleared only by enable
        tamper_in = 1'b1;
        cyc(3 * DIV);
        chk(tamper_flag, "R5 sticky after idle", tamper_flag, 1);
        cfg_write(8'h00);
        cyc(1);
        chk(!tamper_flag, "R5 cleared by enable", tamper_flag, 0);

        // R10 flag only
        tamper_in = 1'b0;
        cyc(4);
        ram_write(7, 8'h5A);
        cfg_write(8'h01);
        tamper_in = 1'b1;
        cyc(8);
        chk(tamper_flag && !clr_busy && !ext_clr, "R10 flag only",
            {tamper_flag, clr_busy, ext_clr}, 4);
        ram_read(7, rd);
        chk(rd == 8'h5A, "R10 ram intact", rd, 8'h5A);

        // R6 R7 internal clear
        cfg_write(8'h00); tamper_in = 1'b0; cyc(4);
        ram_write(3, 8'hAA);
        ram_write(100, 8'h55);
        ram_read(3, rd);
        chk(rd == 8'hAA, "R6 precondition", rd, 8'hAA);
        cfg_write(8'h11);
        tamper_in = 1'b1;
        n = 0;
        while (!clr_busy && n < 20) begin cyc(1); n++; end
        n = 0;
        while (clr_busy && n < 400) begin
            if (n == 20) begin ram_we = 1'b1; ram_addr = 3; ram_wdata = 8'hCC; end
            if (n == 21) ram_we = 1'b0;
            if (n == 30) ram_addr = 100;
            if (n == 32) chk(ram_rdata == 8'hFF, "R7 deselected read", ram_rdata, 8'hFF);
            cyc(1);
            n++;
        end
        chk(n == 128, "R6 busy length", n, 128);
        ram_read(100, rd);
        chk(rd == 8'hFF, "R7 still deselected", rd, 8'hFF);
        cfg_write(8'h00);
        cyc(1);
        ram_read(100, rd);
        chk(rd == 8'h00, "R6 byte cleared", rd, 0);
        ram_read(3, rd);
        chk(rd == 8'h00, "R6 write during busy discarded", rd, 0);

        // R8 external clear widths, R9 tamper reset request
        for (int w = 0; w < 4; w++) begin
            cfg_write(8'h00); tamper_in = 1'b1; cyc(4);
            cfg_write(8'((w << 6) | 8'h23));
            tamper_in = 1'b0;
            n = 0;
            while (!ext_clr && n < 20) begin cyc(1); n++; end
            chk(rst_req, "R9 reset with clear pulse", rst_req, 1);
            n = 0;
            while (ext_clr && n < 200) begin cyc(1); n++; end
            chk(n > DIV * ((1 << w) - 1) && n <= DIV * (1 << w), "R8 pulse width",
                n, DIV * (1 << w));
            chk(!rst_req, "R9 reset released", rst_req, 0);
        end
        cfg_write(8'h00);

        // R9 other sources
        pwr_fail = 1'b1; #1;
        chk(rst_req, "R9 supply fail", rst_req, 1);
        pwr_fail = 1'b0; wdog_expire = 1'b1; #1;
        chk(rst_req, "R9 watchdog", rst_req, 1);
        wdog_expire = 1'b0; man_rst = 1'b1; #1;
        chk(rst_req, "R9 manual", rst_req, 1);
        man_rst = 1'b0; #1;
        chk(!rst_req, "R9 none", rst_req, 0);

        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule